// File: doc/BRIEF.md
# Hierarchical Scan-Out Collection Tree

This block gathers the stored value of whichever scan cell is currently selected and delivers it on one scan-out pin. Every cell offers a data bit together with a select bit, and the select bit is high only while that cell is addressed. The bits pass upward through a tree of four-input macrocells. Each macrocell reduces four data/select pairs to a single pair for the level above. The leaves are the cells themselves, and the first level of macrocells therefore covers groups of four. Two levels cover a four-by-four block of sixteen cells. Further levels continue until a single pair remains.

Each level of the tree can be built with or without output flip-flops. This is chosen by one bit per level in a parameter mask. Registering a level breaks the long reduction path, so a large cell array can be read out over several clock cycles. The cost is one cycle of latency for every registered level. Address decoding is not part of this block. The block expects the select vector to have at most one bit set. When more than one select bit is high, the block raises an error flag that stays set until reset.

Top module: `scan_obs_tree`

## Requirements
- R1: `scan_valid` is the OR of all `cell_sel` bits, seen after the pipeline latency.
- R2: When exactly one `cell_sel` bit i is set, `scan_out` equals `cell_data[i]` after the pipeline latency.
- R3: When no select bit is set, both `scan_out` and `scan_valid` are 0 after the pipeline latency.
- R4: The pipeline latency in clock cycles equals the number of 1 bits in `REG_MASK`. Bit k of the mask registers tree level k, and level 0 is the level nearest the cells.
- R5: When two or more `cell_sel` bits are set, `multi_err` becomes 1. In that case `scan_out` carries the data of the lowest-indexed selected cell.
- R6: Once `multi_err` is 1, it stays 1 until reset. This holds whatever select patterns follow.
- R7: While `rst_n` is low, the registered level outputs and `multi_err` are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered levels and the error flag |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_data | input | 4**LEVELS | Stored value of each scan cell |
| cell_sel | input | 4**LEVELS | Per-cell output-bus select, high when the cell is addressed |
| scan_out | output | 1 | Collected scan-out data |
| scan_valid | output | 1 | High when some cell drove the bus |
| multi_err | output | 1 | Sticky flag set when more than one select bit was high |

## Verification
The hardest case to reach is a double selection whose two cells sit in different groups. A conflict like this is invisible inside either first-level macrocell. It appears only higher up, after a registered level, so the flag rises later than it does for a conflict inside one group. The stimulus therefore applies both kinds of conflict in separate directed phases. Before checking the flag, it waits for more cycles than the full pipeline depth. It also confirms that the lowest-indexed data bit wins in both cases. Random one-hot and empty select patterns are streamed cycle by cycle against a delayed reference model, which exercises every latency stage.

// File: rtl/scan_tree_pkg.sv
package scan_tree_pkg;

  function automatic int unsigned cells_for(input int unsigned levels);
    return 1 << (2 * levels);
  endfunction

  // bit offset where the nodes of tree level k begin in the flat node vector
  function automatic int unsigned level_base(input int unsigned levels,
                                             input int unsigned k);
    int unsigned acc;
    acc = 0;
    for (int unsigned j = 0; j < k; j++) acc += cells_for(levels) >> (2 * j);
    return acc;
  endfunction

  function automatic int unsigned node_bits(input int unsigned levels);
    return level_base(levels, levels) + 1;
  endfunction

  // data of the lowest-indexed child whose select is high, 0 when none is
  function automatic logic pick_lowest(input logic [3:0] dat,
                                       input logic [3:0] sel);
    logic r;
    r = 1'b0;
    for (int i = 3; i >= 0; i--) if (sel[i]) r = dat[i];
    return r;
  endfunction

  function automatic logic many_set(input logic [3:0] sel);
    return $countones(sel) > 1;
  endfunction

endpackage

// File: rtl/scan_macrocell.sv
module scan_macrocell #(
  parameter bit REGD = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] d_in,
  input  logic [3:0] c_in,
  output logic       d_out,
  output logic       c_out,
  output logic       multi
);
  import scan_tree_pkg::*;

  logic d_comb;
  logic c_comb;

  assign d_comb = pick_lowest(d_in, c_in);
  assign c_comb = |c_in;
  assign multi  = many_set(c_in);

  generate
    if (REGD) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          d_out <= 1'b0;
          c_out <= 1'b0;
        end else begin
          d_out <= d_comb;
          c_out <= c_comb;
        end
      end
    end else begin : g_comb
      assign d_out = d_comb;
      assign c_out = c_comb;
    end
  endgenerate

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (c_in == 4'b0) |-> (d_comb == 1'b0));                       // R3
  AST_ONE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(c_in) |-> (d_comb == |(d_in & c_in)));              // R2

endmodule

// File: rtl/scan_tree_level.sv
module scan_tree_level #(
  parameter int unsigned IN_W = 16,
  parameter bit          REGD = 1'b0,
  localparam int unsigned OUT_W = IN_W / 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  d_in,
  input  logic [IN_W-1:0]  c_in,
  output logic [OUT_W-1:0] d_out,
  output logic [OUT_W-1:0] c_out,
  output logic             multi_any
);
  logic [OUT_W-1:0] multi_vec;

  for (genvar g = 0; g < OUT_W; g++) begin : g_cell
    scan_macrocell #(.REGD(REGD)) u_mc (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (d_in[4*g +: 4]),
      .c_in  (c_in[4*g +: 4]),
      .d_out (d_out[g]),
      .c_out (c_out[g]),
      .multi (multi_vec[g])
    );
  end

  assign multi_any = |multi_vec;

endmodule

// File: rtl/scan_obs_tree.sv
module scan_obs_tree #(
  parameter int unsigned          LEVELS   = 3,
  parameter logic [LEVELS-1:0]    REG_MASK = 3'b101,
  localparam int unsigned N_CELLS = scan_tree_pkg::cells_for(LEVELS),
  localparam int unsigned N_NODES = scan_tree_pkg::node_bits(LEVELS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CELLS-1:0] cell_data,
  input  logic [N_CELLS-1:0] cell_sel,
  output logic               scan_out,
  output logic               scan_valid,
  output logic               multi_err
);
  import scan_tree_pkg::*;

  logic [N_NODES-1:0] node_d;
  logic [N_NODES-1:0] node_c;
  logic [LEVELS-1:0]  lvl_multi;
  logic               any_multi;
  logic               err_q;

  assign node_d[N_CELLS-1:0] = cell_data;
  assign node_c[N_CELLS-1:0] = cell_sel;

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    localparam int unsigned IW  = N_CELLS >> (2 * k);
    localparam int unsigned IB  = level_base(LEVELS, k);
    localparam int unsigned OB  = level_base(LEVELS, k + 1);
    scan_tree_level #(.IN_W(IW), .REGD(REG_MASK[k])) u_level (
      .clk       (clk),
      .rst_n     (rst_n),
      .d_in      (node_d[IB +: IW]),
      .c_in      (node_c[IB +: IW]),
      .d_out     (node_d[OB +: IW/4]),
      .c_out     (node_c[OB +: IW/4]),
      .multi_any (lvl_multi[k])
    );
  end

  assign any_multi = |lvl_multi;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | any_multi;
  end

  assign scan_out   = node_d[N_NODES-1];
  assign scan_valid = node_c[N_NODES-1];
  assign multi_err  = err_q;

  AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    scan_out |-> scan_valid);                                   // R3
  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    any_multi |=> multi_err);                                   // R5
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    multi_err |=> multi_err);                                   // R6

endmodule

// File: tb/scan_obs_tree_test.sv
module scan_obs_tree_test;
  localparam int unsigned LEVELS = 3;
  localparam logic [LEVELS-1:0] MASK = 3'b101;
  localparam int unsigned N = 1 << (2 * LEVELS);

  function automatic int unsigned lat_of(input logic [LEVELS-1:0] m);
    int unsigned c;
    c = 0;
    for (int i = 0; i < LEVELS; i++) if (m[i]) c++;
    return c;
  endfunction
  localparam int unsigned LAT = lat_of(MASK);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] cell_data = '0;
  logic [N-1:0] cell_sel = '0;
  logic scan_out, scan_valid, multi_err;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  logic [N-1:0] hd [0:LAT];
  logic [N-1:0] hs [0:LAT];

  always #4 clk = ~clk;

  scan_obs_tree #(.LEVELS(LEVELS), .REG_MASK(MASK)) uut (
    .clk(clk), .rst_n(rst_n), .cell_data(cell_data), .cell_sel(cell_sel),
    .scan_out(scan_out), .scan_valid(scan_valid), .multi_err(multi_err));

  function automatic logic ref_data(input logic [N-1:0] d, input logic [N-1:0] s);
    for (int i = 0; i < N; i++) if (s[i]) return d[i];
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // apply a vector at the negative edge, then compare against the one LAT steps back
  task automatic step(input logic [N-1:0] d, input logic [N-1:0] s, input bit chk_err);
    @(negedge clk);
    for (int i = LAT; i > 0; i--) begin hd[i] = hd[i-1]; hs[i] = hs[i-1]; end
    hd[0] = d; hs[0] = s;
    cell_data = d; cell_sel = s;
    #1;
    check("R1 valid", scan_valid, |hs[LAT]);
    if (hs[LAT] == '0) check("R3 idle data", scan_out, 1'b0);
    else if ($countones(hs[LAT]) == 1) check("R2 data", scan_out, ref_data(hd[LAT], hs[LAT]));
    else check("R5 lowest wins", scan_out, ref_data(hd[LAT], hs[LAT]));
    if (chk_err) check("R5 no false err", multi_err, 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [N-1:0] d, s;
    void'($urandom(32'd1234));
    for (int i = 0; i <= LAT; i++) begin hd[i] = '0; hs[i] = '0; end
    cell_data = '1; cell_sel = {N{1'b1}};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset err", multi_err, 1'b0);
    check("R7 reset valid", scan_valid, 1'b0);
    check("R7 reset data", scan_out, 1'b0);
    cell_sel = '0; cell_data = '0;
    rst_n = 1'b1;

    // R4: single pulse appears exactly LAT cycles later
    step({N{1'b1}}, N'(1) << 37, 1'b1);
    for (int i = 0; i < LAT; i++) step('0, '0, 1'b1);
    // directed edges: cell 0 and cell N-1
    step(N'(1), N'(1), 1'b1);
    step({1'b1, {(N-1){1'b0}}}, {1'b1, {(N-1){1'b0}}}, 1'b1);
    step({1'b0, {(N-1){1'b1}}}, {1'b1, {(N-1){1'b0}}}, 1'b1);
    // random one-hot / empty stream
    for (int t = 0; t < 400; t++) begin
      d = {$urandom, $urandom};
      s = ($urandom_range(0, 3) == 0) ? '0 : (N'(1) << $urandom_range(0, N - 1));
      step(d, s, 1'b1);
    end
    for (int i = 0; i < LAT + 1; i++) step('0, '0, 1'b1);

    // R5: conflict inside one first-level group, lower cell data 0
    d = '0; d[3] = 1'b1; s = '0; s[2] = 1'b1; s[3] = 1'b1;
    step(d, s, 1'b0);
    for (int i = 0; i < LAT + 2; i++) step('0, '0, 1'b0);
    check("R5 err set same group", multi_err, 1'b1);
    // R6: stays set under clean traffic
    for (int t = 0; t < 20; t++) step({$urandom, $urandom}, N'(1) << $urandom_range(0, N - 1), 1'b0);
    check("R6 sticky", multi_err, 1'b1);

    // reset clears, then cross-group conflict
    @(negedge clk); rst_n = 1'b0; cell_sel = '0;
    repeat (2) @(negedge clk);
    check("R7 err cleared", multi_err, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i <= LAT; i++) begin hd[i] = '0; hs[i] = '0; end
    for (int i = 0; i < LAT + 1; i++) step('0, '0, 1'b1);
    d = '0; d[5] = 1'b1; s = '0; s[5] = 1'b1; s[40] = 1'b1;
    step(d, s, 1'b1);
    for (int i = 0; i < LAT + 2; i++) step('0, '0, 1'b0);
    check("R5 err set cross group", multi_err, 1'b1);
    step('0, '0, 1'b0);
    check("R6 sticky idle", multi_err, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule